// File: doc/BRIEF.md
# Bit-Serial Priority Bus Arbiter

This block models a group of nodes that share one serial line whose resolved level is the logical OR of every active driver. When the line is free and at least one node is asking for it, a contention round begins. Each requesting node sends its own unique priority number onto the line, most significant bit first, one bit per clock. A node that sends a 0 but reads back a 1 knows that a higher number is present. It stops driving for the rest of the round. When the last bit has been sent, only the node with the largest number is left. That node receives a single-cycle grant.

The winner then owns the line for a fixed busy interval, which stands in for its data transfer. A new round starts as soon as that interval ends. Nodes that lost keep their request asserted and compete again. No central comparator picks the winner: the decision is made bit by bit on the shared line, by every node watching the same resolved value.

Top module: `bpa_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `grant` is all zeros, `arb_done` is 0, `bus_busy` is 0 and `bus_line` is 0.
- R2: A round starts at the first clock edge where the arbiter is idle and any `req` bit is 1. Only nodes whose `req` bit is 1 at that edge take part. A request raised later in the round does not change its outcome and waits for a following round.
- R3: During a round the node number of node i is `node_id[i*ID_W +: ID_W]`. Its bits are placed on the line from bit ID_W-1 down to bit 0, one bit per cycle, starting in the cycle after the start edge. `bus_line` equals the OR of the current bit of every node still competing.
- R4: A competing node whose current bit is 0 while `bus_line` is 1 withdraws from the next cycle on. As a result, `bus_line` traces the largest competing node number, bit by bit.
- R5: In the cycle after the ID_W bit cycles, `arb_done` is 1 for exactly one cycle. In that same cycle `grant` has exactly one bit set: the competing node with the largest number (bit i means node i). Outside that cycle `grant` is zero.
- R6: If the line is idle, the highest-numbered requester is granted ID_W+1 cycles after it raises its request.
- R7: After the grant cycle, `bus_busy` is 1 for exactly XFER_CYCLES cycles. During that interval no round runs and `bus_line` is 0. If requests are pending when the interval ends, the next round starts on the following clock edge.
- R8: While no `req` bit is 1, the arbiter stays idle: no grant, no `arb_done`, and `bus_line` stays 0.
- R9: A node that lost a round and keeps `req` high competes in the next round. It is granted there if it is then the largest requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_NODES | Per-node request for the line |
| node_id | input | N_NODES*ID_W | Packed unique priority numbers, node i in slice i |
| bus_line | output | 1 | Resolved wired-OR level of the shared line |
| grant | output | N_NODES | One-cycle grant, one bit per node |
| arb_done | output | 1 | Pulses in the cycle a round resolves |
| bus_busy | output | 1 | High during the winner's fixed transfer interval |

## Verification
The node numbers in the test are chosen so that different request sets expose different failures:
- Two numbers differ only in their lowest bit, which catches an error on the final comparison step.
- Other numbers diverge at the top bit, which checks that an early withdrawal takes effect.
- A request set whose OR has many more 1 bits than its maximum shows whether losers really stop driving, because the traced `bus_line` would otherwise be wrong.

Directed cases cover the following:
- A request arriving mid-round, which must be ignored in that round.
- A loser that holds its request, which must win the round after.
- A stretch with no requests at all.
- Back-to-back rounds, which check the exact length of the busy gap.

// File: rtl/bpa_pkg.sv
// Shared types for the bit-serial priority bus arbiter.
package bpa_pkg;

    // Phase of the shared line as seen by the round sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARB   = 2'd1,
        ST_GRANT = 2'd2,
        ST_XFER  = 2'd3
    } bpa_state_e;

endpackage

// File: rtl/bpa_node.sv
// One contending node.
// Purpose: latches its request when a round starts, drives the current bit
//   of its number onto the line, and withdraws when it sends 0 and sees 1.
// Assumptions: ID_W >= 2; bit_sel counts down from ID_W-1 to 0 while arb_tick is high.
module bpa_node #(
    parameter int ID_W = 8,
    localparam int BW  = $clog2(ID_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            arb_tick,
    input  logic [BW-1:0]   bit_sel,
    input  logic            req,
    input  logic [ID_W-1:0] id,
    input  logic            bus_in,
    output logic            drive,
    output logic            active
);

    logic my_bit;

    // Current bit of this node's number.
    always_comb my_bit = id[bit_sel];

    // Only a node still in the round places its bit on the line.
    always_comb drive = active & arb_tick & my_bit;

    // Join on the round start; drop out on a lost bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (start) begin
            active <= req;
        end else if (arb_tick && active && !my_bit && bus_in) begin
            active <= 1'b0;
        end
    end

endmodule

// File: rtl/bpa_bus_or.sv
// Resolves the shared line: it reads 1 when any driver pushes a 1.
// Assumption: drivers are already gated to zero outside the bit phase.
module bpa_bus_or #(
    parameter int N_NODES = 4
) (
    input  logic [N_NODES-1:0] drv,
    output logic               line
);

    // Wired-OR resolution.
    always_comb line = |drv;

endmodule

// File: rtl/bpa_sequencer.sv
// Round sequencer.
// Purpose: steps through idle, ID_W bit cycles, one grant cycle and
//   XFER_CYCLES busy cycles.
// Assumptions: ID_W >= 2 and XFER_CYCLES >= 1.
module bpa_sequencer
    import bpa_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int XFER_CYCLES = 4,
    localparam int BW         = $clog2(ID_W),
    localparam int XW         = $clog2(XFER_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    output logic          start,
    output logic          arb_tick,
    output logic [BW-1:0] bit_sel,
    output logic          grant_en,
    output logic          busy
);

    bpa_state_e    state;
    logic [BW-1:0] bit_cnt;
    logic [XW-1:0] xfer_cnt;

    // Decode of the current phase.
    always_comb begin
        start    = (state == ST_IDLE) && any_req;
        arb_tick = (state == ST_ARB);
        grant_en = (state == ST_GRANT);
        busy     = (state == ST_XFER);
        bit_sel  = bit_cnt;
    end

    // Phase transitions and their counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            xfer_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any_req) begin
                        state   <= ST_ARB;
                        bit_cnt <= BW'(ID_W - 1);
                    end
                end
                ST_ARB: begin
                    if (bit_cnt == '0) begin
                        state <= ST_GRANT;
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                ST_GRANT: begin
                    state    <= ST_XFER;
                    xfer_cnt <= XW'(XFER_CYCLES - 1);
                end
                ST_XFER: begin
                    if (xfer_cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        xfer_cnt <= xfer_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bpa_arbiter.sv
// Bit-serial priority arbiter top.
// Purpose: instantiates one node per requester, the wired-OR line and the
//   round sequencer.
// Assumptions: node numbers are unique; ID_W >= 2; XFER_CYCLES >= 1.
module bpa_arbiter #(
    parameter int N_NODES     = 4,
    parameter int ID_W        = 8,
    parameter int XFER_CYCLES = 4,
    localparam int BW         = $clog2(ID_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_NODES-1:0]      req,
    input  logic [N_NODES*ID_W-1:0] node_id,
    output logic                    bus_line,
    output logic [N_NODES-1:0]      grant,
    output logic                    arb_done,
    output logic                    bus_busy
);

    logic               start;
    logic               arb_tick;
    logic [BW-1:0]      bit_sel;
    logic               grant_en;
    logic [N_NODES-1:0] drv;
    logic [N_NODES-1:0] active;

    bpa_sequencer #(
        .ID_W       (ID_W),
        .XFER_CYCLES(XFER_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (|req),
        .start   (start),
        .arb_tick(arb_tick),
        .bit_sel (bit_sel),
        .grant_en(grant_en),
        .busy    (bus_busy)
    );

    for (genvar i = 0; i < N_NODES; i++) begin : g_node
        bpa_node #(
            .ID_W(ID_W)
        ) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .arb_tick(arb_tick),
            .bit_sel (bit_sel),
            .req     (req[i]),
            .id      (node_id[i*ID_W +: ID_W]),
            .bus_in  (bus_line),
            .drive   (drv[i]),
            .active  (active[i])
        );
    end

    bpa_bus_or #(
        .N_NODES(N_NODES)
    ) u_line (
        .drv (drv),
        .line(bus_line)
    );

    // The survivor of the round is granted in the grant cycle.
    always_comb begin
        grant    = active & {N_NODES{grant_en}};
        arb_done = grant_en;
    end

endmodule

// File: rtl/bpa_arbiter_chk.sv
// Protocol checker for bpa_arbiter, attached with bind.
module bpa_arbiter_chk #(
    parameter int N_NODES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_NODES-1:0] grant,
    input logic               arb_done,
    input logic               bus_busy,
    input logic               bus_line
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5

    AST_DONE_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        arb_done |-> ($countones(grant) == 1)); // R5

    AST_GRANT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> arb_done); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_done |=> !arb_done); // R5

    AST_BUSY_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_done |=> bus_busy); // R7

    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_done || bus_busy) |-> !bus_line); // R7

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> !arb_done); // R7

endmodule

bind bpa_arbiter bpa_arbiter_chk #(.N_NODES(N_NODES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant   (grant),
    .arb_done(arb_done),
    .bus_busy(bus_busy),
    .bus_line(bus_line)
);

// File: tb/bpa_arbiter_test.sv
module bpa_arbiter_test;

    localparam int N    = 4;
    localparam int IDW  = 8;
    localparam int XFER = 4;

    // Node numbers: 3 and 1 differ only in bit 0; 2 has many ones.
    localparam logic [N*IDW-1:0] IDS = {8'hA3, 8'h7F, 8'hA2, 8'h35};

    // Each vector is {requests, expected grant}.
    localparam int NV = 7;
    localparam logic [7:0] VEC [NV] = '{
        {4'b0001, 4'b0001},
        {4'b0011, 4'b0010},
        {4'b0101, 4'b0100},
        {4'b0110, 4'b0010},
        {4'b1010, 4'b1000},
        {4'b1111, 4'b1000},
        {4'b0111, 4'b0010}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N*IDW-1:0] node_id = IDS;
    logic           bus_line;
    logic [N-1:0]   grant;
    logic           arb_done;
    logic           bus_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bpa_arbiter #(.N_NODES(N), .ID_W(IDW), .XFER_CYCLES(XFER)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .node_id (node_id),
        .bus_line(bus_line),
        .grant   (grant),
        .arb_done(arb_done),
        .bus_busy(bus_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [IDW-1:0] max_id(input logic [N-1:0] r);
        logic [IDW-1:0] m = '0;
        for (int i = 0; i < N; i++)
            if (r[i] && IDS[i*IDW +: IDW] > m) m = IDS[i*IDW +: IDW];
        return m;
    endfunction

    // Counts busy cycles after a grant; returns with the arbiter idle.
    task automatic check_busy(input string tag);
        int n = 0;
        int quiet = 1;
        @(negedge clk);
        while (bus_busy && n < 100) begin
            n++;
            if (bus_line || arb_done) quiet = 0;
            @(negedge clk);
        end
        check(n == XFER, {tag, " busy length"}, n, XFER);
        check(quiet == 1, {tag, " line quiet while busy"}, quiet, 1);
    endtask

    // Waits for arb_done and returns the number of negedges waited.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!arb_done && n < 100);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [IDW-1:0] m;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(grant == '0 && !arb_done && !bus_busy && !bus_line, "R1 during reset",
              {grant, arb_done, bus_busy, bus_line}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant == '0 && !arb_done && !bus_busy && !bus_line, "R1 after reset",
              {grant, arb_done, bus_busy, bus_line}, 0);

        // Vector table: line trace, grant and timing.
        for (int v = 0; v < NV; v++) begin
            req = VEC[v][7:4];
            m = max_id(req);
            for (int b = IDW - 1; b >= 0; b--) begin
                @(negedge clk);
                check(bus_line == m[b], "R3 R4 line bit", bus_line, m[b]);
            end
            @(negedge clk);
            // R5 R6: grant one cycle after the ID_W bit cycles.
            check(arb_done == 1'b1, "R5 R6 done timing", arb_done, 1);
            check(grant == VEC[v][3:0], "R5 winner", grant, VEC[v][3:0]);
            req = '0;
            check_busy("R7");
        end

        // R8: no requests, no activity.
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (arb_done || grant != '0 || bus_line || bus_busy) n++;
        end
        check(n == 0, "R8 idle quiet", n, 0);

        // R2: late request ignored; it then wins the next round (R9 style hold).
        req = 4'b0010;
        repeat (3) @(negedge clk);
        req = 4'b1010;
        wait_done(n);
        check(n == IDW - 2, "R2 round timing", n, IDW - 2);
        check(grant == 4'b0010, "R2 late request ignored", grant, 4'b0010);
        req = 4'b1000;
        check_busy("R7 round a");
        wait_done(n);
        // R7: restart on the edge after the busy interval.
        check(n == IDW + 1, "R7 restart latency", n, IDW + 1);
        check(grant == 4'b1000, "R2 waiting request served", grant, 4'b1000);
        req = '0;
        check_busy("R7 round b");

        // R9: loser holds its request and wins the next round.
        req = 4'b0011;
        wait_done(n);
        check(grant == 4'b0010, "R9 first winner", grant, 4'b0010);
        req = 4'b0001;
        check_busy("R7 round c");
        wait_done(n);
        check(n == IDW + 1 && grant == 4'b0001, "R9 loser wins later", grant, 4'b0001);
        req = '0;
        check_busy("R7 round d");

        // R1: reset mid-round clears everything.
        req = 4'b1111;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        @(negedge clk);
        check(grant == '0 && !arb_done && !bus_busy && !bus_line, "R1 mid-round reset",
              {grant, arb_done, bus_busy, bus_line}, 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(!arb_done && !bus_line, "R8 idle after reset", {arb_done, bus_line}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule